// File: doc/BRIEF.md
# Four-Lane Word Deskew

This block takes four byte lanes that carry one 32-bit word striped across them and removes the skew between the lanes. Each lane presents decoded characters on a shared clock, each with a control-character flag and its own valid. Every lane writes into its own small elastic FIFO. The transmitter sends an alignment marker on all four lanes in the same word. The marker is the byte 0xBC with the control flag set. After reset, and after any loss of alignment, each lane drops its characters until its marker arrives. When every lane holds its marker and the lanes are within the selected skew window, all four FIFOs are read in lockstep. The receiver then rebuilds exactly the word that was sent.

A two-bit select sets the skew window. Wider windows tolerate more skew but have a longer fixed receive latency. A status pin reports whether the selected window is narrow enough for alignment across more than one device. The output stream uses valid/ready. While `out_ready` is low, `out_valid` and `out_data` hold. The lanes themselves cannot be stalled, so the FIFOs absorb any back-pressure. If back-pressure lasts so long that a FIFO would overflow, alignment is lost and the search starts again.

Top module: `lane_word_deskew`

## Requirements
- R1: Each output word holds the four bytes of one transmit word, with lane 0 in bits 7:0 and lane 3 in bits 31:24. Bytes from adjacent transmit words are never combined. Words come out in transmit order.
- R2: The marker is data byte 0xBC with its lane's control flag at 1. While searching, a lane discards every character before its marker. The marker word 0xBCBCBCBC is the first word output after alignment.
- R3: The window is counted in characters from the cycle of the earliest marker. Select 01 gives 1 character, 00 gives 4 and 10 gives 9. If every lane's marker arrives within the window, `aligned` goes to 1 and `align_err` goes to 0.
- R4: If any lane's marker is still missing when the window ends, `align_err` goes to 1, `aligned` stays at 0 and all FIFOs are flushed. The search restarts, and `align_err` stays at 1 until the next successful alignment.
- R5: The first output word is valid exactly window+1 cycles after the cycle in which the earliest marker is presented. Latency therefore grows with the window setting.
- R6: Select 11 is reserved. While it is applied, `aligned` is 0, `align_err` is 1, no word is output and the FIFOs are held flushed. Leaving 11 starts a fresh search.
- R7: `multi_dev` is 1 for selects 00 and 01 and 0 for selects 10 and 11.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value. A word is consumed only when both are 1, and no word is lost or repeated.
- R9: If a lane writes into a full FIFO while aligned, `align_err` goes to 1, `aligned` goes to 0, all FIFOs are flushed and the search restarts.
- R10: After reset, `aligned` is 0, `align_err` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_valid | input | 4 | Per-lane character valid |
| lane_data | input | 32 | Lane i character in bits 8i+7:8i |
| lane_k | input | 4 | Per-lane control-character flag |
| skew_sel | input | 2 | Skew window select (01:1, 00:4, 10:9 characters, 11 reserved) |
| out_valid | output | 1 | Aligned word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Recovered word, lane 0 in the low byte |
| aligned | output | 1 | Lanes are locked together |
| align_err | output | 1 | Alignment failed, overflowed, or reserved select applied |
| multi_dev | output | 1 | Selected window supports alignment across devices |

## Verification
The main function is exercised with random per-lane delays inside each of the three windows, shifted by a random common offset. This separates true lockstep reads from reads that merely happen to line up at zero skew. It also checks that the fixed latency follows the window and not the actual skew. A second set of patterns puts one lane exactly one or more characters beyond the window, which exposes an off-by-one in the window counter. Random ready gaps and a sustained stall test the hold rule and the overflow path. Cycles of reserved-select application between runs show that the FIFOs are flushed and the search starts afresh.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  localparam logic [7:0] MARKER_BYTE = 8'hBC;

  typedef enum logic [1:0] {
    SEL_MID    = 2'b00,
    SEL_NARROW = 2'b01,
    SEL_WIDE   = 2'b10,
    SEL_RSVD   = 2'b11
  } skew_sel_e;

  typedef enum logic {
    ST_SEARCH  = 1'b0,
    ST_ALIGNED = 1'b1
  } align_st_e;
endpackage

// File: rtl/lwd_lane_fifo.sv
// Per-lane elastic FIFO. Until the lane's marker is seen, nothing is written.
// DEPTH must be a power of two.
module lwd_lane_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_k,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          locked,
  output logic          lock_now,
  output logic          overflow
);
  import lwd_pkg::*;

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, rd_q, level;
  logic          is_marker, wr_en, full;

  assign is_marker = in_k && (in_data == MARKER_BYTE[DW-1:0]);
  assign lock_now  = !locked && in_valid && is_marker;
  assign wr_en     = in_valid && (locked || is_marker);
  assign level     = wr_q - rd_q;
  assign empty     = (level == '0);
  assign full      = (level == (AW+1)'(DEPTH));
  assign overflow  = wr_en && full;
  assign head      = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q   <= '0;
      rd_q   <= '0;
      locked <= 1'b0;
    end else begin
      if (wr_en && !full) wr_q <= wr_q + 1'b1;
      if (lock_now)       locked <= 1'b1;
      if (pop)            rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full && !flush) mem[wr_q[AW-1:0]] <= in_data;
  end

  // R1: lockstep reads never take from an empty lane
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9: a write into a full FIFO is answered by a flush in the same cycle
  p_overflow_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> flush);
endmodule

// File: rtl/lwd_align_ctrl.sv
// Skew window timing, alignment decision and error handling.
module lwd_align_ctrl #(
  parameter int LANES      = 4,
  parameter int WIN_NARROW = 1,
  parameter int WIN_MID    = 4,
  parameter int WIN_WIDE   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       skew_sel,
  input  logic [LANES-1:0] lock_now,
  input  logic [LANES-1:0] locked,
  input  logic [LANES-1:0] overflow,
  output logic             flush,
  output logic             aligned,
  output logic             align_err,
  output logic             multi_dev
);
  import lwd_pkg::*;

  localparam int WMAX0 = (WIN_NARROW > WIN_MID) ? WIN_NARROW : WIN_MID;
  localparam int WMAX  = (WMAX0 > WIN_WIDE) ? WMAX0 : WIN_WIDE;
  localparam int CW    = $clog2(WMAX + 2);

  align_st_e st_q, st_d;
  logic          started_q, started_d, err_q, err_d;
  logic [CW-1:0] cnt_q, cnt_d, win;
  logic          reserved, all_next;

  always_comb begin
    case (skew_sel_e'(skew_sel))
      SEL_NARROW: win = CW'(WIN_NARROW);
      SEL_MID:    win = CW'(WIN_MID);
      default:    win = CW'(WIN_WIDE);
    endcase
  end

  assign reserved  = (skew_sel_e'(skew_sel) == SEL_RSVD);
  assign all_next  = &(locked | lock_now);
  assign multi_dev = (skew_sel_e'(skew_sel) == SEL_MID) ||
                     (skew_sel_e'(skew_sel) == SEL_NARROW);
  assign aligned   = (st_q == ST_ALIGNED) && !reserved;
  assign align_err = err_q || reserved;

  always_comb begin
    st_d      = st_q;
    started_d = started_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    flush     = 1'b0;
    if (reserved) begin
      flush     = 1'b1;
      st_d      = ST_SEARCH;
      started_d = 1'b0;
      cnt_d     = '0;
    end else if (st_q == ST_ALIGNED) begin
      if (|overflow) begin
        flush = 1'b1;
        st_d  = ST_SEARCH;
        err_d = 1'b1;
      end
    end else if (!started_q) begin
      if (|lock_now) begin
        started_d = 1'b1;
        cnt_d     = CW'(1);
      end
    end else if (cnt_q >= win) begin
      started_d = 1'b0;
      cnt_d     = '0;
      if (all_next) begin
        st_d  = ST_ALIGNED;
        err_d = 1'b0;
      end else begin
        flush = 1'b1;
        err_d = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_SEARCH;
      started_q <= 1'b0;
      cnt_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      started_q <= started_d;
      cnt_q     <= cnt_d;
      err_q     <= err_d;
    end
  end

  // R3: entering alignment leaves every lane holding its marker
  p_enter_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEARCH && st_d == ST_ALIGNED) |=> (&locked));
  // R4: a flush clears every lane's lock
  p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (locked == '0));
  // R6: the reserved select forces the search state with no window open
  p_reserved_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |=> (st_q == ST_SEARCH && !started_q));
endmodule

// File: rtl/lane_word_deskew.sv
module lane_word_deskew #(
  parameter int LANES      = 4,
  parameter int DW         = 8,
  parameter int DEPTH      = 32,
  parameter int WIN_NARROW = 1,
  parameter int WIN_MID    = 4,
  parameter int WIN_WIDE   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    lane_valid,
  input  logic [LANES*DW-1:0] lane_data,
  input  logic [LANES-1:0]    lane_k,
  input  logic [1:0]          skew_sel,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*DW-1:0] out_data,
  output logic                aligned,
  output logic                align_err,
  output logic                multi_dev
);
  logic [LANES-1:0] empty, locked, lock_now, overflow;
  logic             flush, pop_all;

  assign out_valid = aligned && !(|empty);
  assign pop_all   = out_valid && out_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lwd_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .in_valid (lane_valid[i]),
      .in_data  (lane_data[i*DW +: DW]),
      .in_k     (lane_k[i]),
      .pop      (pop_all),
      .head     (out_data[i*DW +: DW]),
      .empty    (empty[i]),
      .locked   (locked[i]),
      .lock_now (lock_now[i]),
      .overflow (overflow[i])
    );
  end

  lwd_align_ctrl #(
    .LANES(LANES), .WIN_NARROW(WIN_NARROW), .WIN_MID(WIN_MID), .WIN_WIDE(WIN_WIDE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .skew_sel  (skew_sel),
    .lock_now  (lock_now),
    .locked    (locked),
    .overflow  (overflow),
    .flush     (flush),
    .aligned   (aligned),
    .align_err (align_err),
    .multi_dev (multi_dev)
  );

  // R8: a stalled word holds until taken, unless the reserved select intervenes
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      ((out_valid && $stable(out_data)) || skew_sel == 2'b11));
  // R1: output words exist only while every lane is locked
  p_valid_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (&locked));
endmodule

// File: tb/lane_word_deskew_bench.sv
module lane_word_deskew_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lane_valid = '0;
  logic [31:0] lane_data = '0;
  logic [3:0]  lane_k = '0;
  logic [1:0]  skew_sel = 2'b00;
  logic        out_ready = 1'b0;
  logic        out_valid, aligned, align_err, multi_dev;
  logic [31:0] out_data;

  int          n_chk = 0, n_fail = 0, cyc = 0, first_v_cyc = 0;
  bit          first_seen = 1'b0, first_word = 1'b0, done = 1'b0;
  logic [31:0] exp_q[$];

  lane_word_deskew u_lane_word_deskew (
    .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
    .lane_k(lane_k), .skew_sel(skew_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .aligned(aligned),
    .align_err(align_err), .multi_dev(multi_dev)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !first_seen) begin
      first_seen  = 1'b1;
      first_v_cyc = cyc;
    end
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected output word", out_data, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (first_word) chk(out_data == e, "R2", "marker word first", out_data, e);
        else            chk(out_data == e, "R1", "recovered word", out_data, e);
        first_word = 1'b0;
      end
    end
  end

  task automatic run_trial(input logic [1:0] code, input int win, input bit beyond,
                           input int nwords, input bit stall);
    int d[4];
    logic [7:0] b[4][64];
    int dmin, dmax, mark_cyc, total;
    // reserved select: flush and restart search (R6)
    @(posedge clk); #1 skew_sel = 2'b11; lane_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!aligned && align_err && !out_valid, "R6", "reserved select state",
        {aligned, align_err, out_valid}, 3'b010);
    @(posedge clk); #1 skew_sel = code;
    @(negedge clk);
    chk(multi_dev == (code == 2'b00 || code == 2'b01), "R7", "multi_dev flag",
        multi_dev, (code == 2'b00 || code == 2'b01));
    for (int i = 0; i < 4; i++) d[i] = $urandom_range(0, win);
    if (beyond) begin
      int j;
      j = $urandom_range(0, 3);
      d[j] = win + 1 + $urandom_range(0, 2);
      d[(j + 1) % 4] = 0;
    end else begin
      int off;
      off = $urandom_range(0, 3);
      for (int i = 0; i < 4; i++) d[i] += off;
    end
    dmin = d[0]; dmax = d[0];
    for (int i = 1; i < 4; i++) begin
      if (d[i] < dmin) dmin = d[i];
      if (d[i] > dmax) dmax = d[i];
    end
    for (int n = 0; n < nwords; n++)
      for (int i = 0; i < 4; i++) b[i][n] = (n == 0) ? 8'hBC : 8'($urandom);
    if (!beyond && !stall)
      for (int n = 0; n < nwords; n++) exp_q.push_back({b[3][n], b[2][n], b[1][n], b[0][n]});
    first_seen = 1'b0;
    first_word = 1'b1;
    mark_cyc = 0;
    total = nwords + dmax + 1;
    for (int c = 0; c < total; c++) begin
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        if (c < d[i]) begin
          lane_valid[i] = 1'b1; lane_data[i*8 +: 8] = 8'h00; lane_k[i] = 1'b0;
        end else if (c - d[i] < nwords) begin
          lane_valid[i] = 1'b1; lane_data[i*8 +: 8] = b[i][c - d[i]];
          lane_k[i] = (c == d[i]);
        end else begin
          lane_valid[i] = 1'b0; lane_data[i*8 +: 8] = 8'h00; lane_k[i] = 1'b0;
        end
      end
      out_ready = stall ? 1'b0 : ($urandom_range(0, 3) != 0);
      if (c == dmin) mark_cyc = cyc;
    end
    @(posedge clk); #1 lane_valid = '0; lane_k = '0; out_ready = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    if (stall) begin
      chk(align_err && !aligned, "R9", "overflow loses alignment",
          {aligned, align_err}, 2'b01);
    end else if (beyond) begin
      chk(align_err && !aligned && !out_valid, "R4", "skew beyond window",
          {aligned, align_err, out_valid}, 3'b010);
    end else begin
      chk(first_seen && (first_v_cyc - mark_cyc == win + 1), "R5", "first word latency",
          first_v_cyc - mark_cyc, win + 1);
      chk(aligned && !align_err, "R3", "aligned within window",
          {aligned, align_err}, 2'b10);
      chk(exp_q.size() == 0, "R8", "all words delivered", exp_q.size(), 0);
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!aligned && !align_err && !out_valid, "R10", "reset state",
        {aligned, align_err, out_valid}, 3'b000);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!aligned && !align_err && !out_valid, "R10", "state after reset release",
        {aligned, align_err, out_valid}, 3'b000);
    for (int r = 0; r < 3; r++) begin
      run_trial(2'b01, 1, 1'b0, 24, 1'b0);
      run_trial(2'b00, 4, 1'b0, 24, 1'b0);
      run_trial(2'b10, 9, 1'b0, 24, 1'b0);
    end
    run_trial(2'b01, 1, 1'b1, 24, 1'b0);
    run_trial(2'b00, 4, 1'b1, 24, 1'b0);
    run_trial(2'b10, 9, 1'b1, 24, 1'b0);
    run_trial(2'b00, 4, 1'b0, 24, 1'b0);   // recovery after error (R4)
    run_trial(2'b00, 4, 1'b0, 56, 1'b1);   // sustained stall (R9)
    @(posedge clk); #1 skew_sel = 2'b11;
    @(negedge clk);
    chk(multi_dev == 1'b0, "R7", "multi_dev for reserved", multi_dev, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule